// File: doc/BRIEF.md
# Configurable Interrupt Aggregator

This block merges a set of internal event lines into one interrupt pin for a host processor. Each event line first passes through a two-flop synchroniser. A per-source two-bit setting then decides whether the line counts on a rising edge, on a falling edge, while it is high, or not at all. Edge events are caught in sticky status bits that the host clears. A level source shows its current synchronised value directly.

The host reaches four registers through a plain single-cycle register port: status, mask, per-source sensitivity, and pin drive. The interrupt is active when any status bit is set and its mask bit enables it. The pin can be push-pull active-high, push-pull active-low, or low-only open-drain. In open-drain mode, several devices can share one wired-OR line. The pad is modelled as a data output and an output-enable, and the pad cell sits outside this block. There is no streamed data in this block, so every pin is a plain control or status signal with no handshake.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset the status reads 0, the mask reads 0 (all sources masked), every sensitivity field reads 2'b11, the drive field reads 2'b00, and the pin shows irq_o=0 with irq_oe=1.
- R2: A source with sensitivity 2'b00 latches its status bit on a 0-to-1 input change. The bit, and the pin, show the event after the third rising clock edge following the input change. They show nothing after the second edge.
- R3: A source with sensitivity 2'b01 latches its status bit on a 1-to-0 input change and ignores 0-to-1 changes.
- R4: A source with sensitivity 2'b10 has a status bit equal to its synchronised input level. The bit is never held after the input falls.
- R5: A source with sensitivity 2'b11 is disabled. Its status bit reads 0 whatever the input does, and it never raises the interrupt.
- R6: Writing register 0 clears each latched edge bit whose write-data bit is 1, and leaves bits written with 0 unchanged.
- R7: Reading register 0 clears every latched edge bit. An edge that arrives in the same cycle as a clear stays set.
- R8: The interrupt is active exactly when status AND mask is nonzero, where a mask bit of 1 enables its source. Status bits remain readable whatever the mask holds.
- R9: Drive field 2'b00 gives irq_o=active with irq_oe=1. Field 2'b01 gives irq_o=!active with irq_oe=1. Field 2'b10 gives irq_o=0 with irq_oe=active, so the line is released when idle. Field 2'b11 behaves as 2'b01.
- R10: The register map is address 0 status, address 1 mask, address 2 sensitivity, and address 3 drive in bits [1:0]. Source i uses bit i of status and mask, and bits [2i+1:2i] of sensitivity. Read data is registered, appears the cycle after reg_rd, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N_SRC | Asynchronous event lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2*N_SRC | Write data |
| reg_rdata | output | 2*N_SRC | Registered read data |
| irq_o | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The assertions assume that reg_wr and reg_rd are never high together. They also assume that event lines are low while reset is held, so the edge detector starts from a known previous level. The stimulus drives every input only on falling clock edges, keeps reset long enough for the synchroniser to fill with zeros, and issues one register access at a time. After each change on the event lines, the stimulus waits at least four cycles before it reads or clears the status, which keeps every expected value clear of the synchroniser delay.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  typedef enum logic [1:0] {
    SM_RISE  = 2'b00,
    SM_FALL  = 2'b01,
    SM_LEVEL = 2'b10,
    SM_OFF   = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    PD_HIGH    = 2'b00,
    PD_LOW     = 2'b01,
    PD_OPEN    = 2'b10,
    PD_LOW_ALT = 2'b11
  } pin_drive_e;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_MODE   = 2'd2;
  localparam logic [1:0] A_DRIVE  = 2'd3;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, safe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d_i;
      safe_q <= meta_q;
    end
  end

  assign q_o = safe_q;
endmodule

// File: rtl/evt_src_cell.sv
module evt_src_cell
  import evt_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  src_mode_e mode_i,
  input  logic      lvl_i,
  input  logic      clr_i,
  output logic      stat_o
);
  logic prev_q, stk_q, hit, edge_mode;

  assign edge_mode = (mode_i == SM_RISE) || (mode_i == SM_FALL);
  assign hit = ((mode_i == SM_RISE) && lvl_i && !prev_q) ||
               ((mode_i == SM_FALL) && !lvl_i && prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stk_q  <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      if (edge_mode) stk_q <= (stk_q && !clr_i) || hit;
      else           stk_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (mode_i)
      SM_LEVEL: stat_o = lvl_i;
      SM_OFF:   stat_o = 1'b0;
      default:  stat_o = stk_q;
    endcase
  end

  // R2: an upward change in rising mode is latched on the next edge
  p_rise_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SM_RISE && lvl_i && !prev_q) |=> stk_q);

  // R3: a downward change in falling mode is latched on the next edge
  p_fall_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SM_FALL && !lvl_i && prev_q) |=> stk_q);

  // R6/R7: a clear with no new event empties the latch
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !(lvl_i ^ prev_q)) |=> !stk_q);

  // R7: without a clear, a latched edge survives while an edge mode is kept
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_q && !clr_i && edge_mode) |=> (stk_q || mode_i == SM_LEVEL || mode_i == SM_OFF));
endmodule

// File: rtl/evt_pin_drv.sv
module evt_pin_drv
  import evt_irq_pkg::*;
(
  input  logic       active_i,
  input  pin_drive_e drive_i,
  output logic       pin_o,
  output logic       pin_oe
);
  always_comb begin
    unique case (drive_i)
      PD_HIGH: begin pin_o = active_i;  pin_oe = 1'b1;     end
      PD_OPEN: begin pin_o = 1'b0;      pin_oe = active_i; end
      default: begin pin_o = !active_i; pin_oe = 1'b1;     end
    endcase
  end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
  import evt_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_i,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [1:0]           reg_addr,
  input  logic [2*N_SRC-1:0]   reg_wdata,
  output logic [2*N_SRC-1:0]   reg_rdata,
  output logic                 irq_o,
  output logic                 irq_oe
);
  localparam int DW = 2 * N_SRC;

  logic [N_SRC-1:0] lvl, status, mask_q, clr;
  logic [DW-1:0]    mode_q;
  pin_drive_e       drive_q;
  logic             active, wr_stat, rd_stat;

  evt_sync #(.WIDTH(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(src_i), .q_o(lvl)
  );

  assign wr_stat = reg_wr && (reg_addr == A_STATUS);
  assign rd_stat = reg_rd && (reg_addr == A_STATUS);
  assign clr     = ({N_SRC{wr_stat}} & reg_wdata[N_SRC-1:0]) | {N_SRC{rd_stat}};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    evt_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (src_mode_e'(mode_q[2*i +: 2])),
      .lvl_i  (lvl[i]),
      .clr_i  (clr[i]),
      .stat_o (status[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      mode_q  <= '1;
      drive_q <= PD_HIGH;
    end else if (reg_wr) begin
      case (reg_addr)
        A_MASK:  mask_q  <= reg_wdata[N_SRC-1:0];
        A_MODE:  mode_q  <= reg_wdata;
        A_DRIVE: drive_q <= pin_drive_e'(reg_wdata[1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STATUS: reg_rdata <= DW'(status);
        A_MASK:   reg_rdata <= DW'(mask_q);
        A_MODE:   reg_rdata <= mode_q;
        default:  reg_rdata <= DW'(drive_q);
      endcase
    end
  end

  assign active = |(status & mask_q);

  evt_pin_drv u_pin (
    .active_i(active), .drive_i(drive_q), .pin_o(irq_o), .pin_oe(irq_oe)
  );

  // R5: a disabled source never contributes a status bit
  for (genvar j = 0; j < N_SRC; j++) begin : g_chk
    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[2*j +: 2] == 2'b11) |-> !status[j]);
  end

  // R8: in active-high drive the pin tracks enabled status
  p_pin_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q == PD_HIGH) |-> (irq_o == |(status & mask_q)));

  // R9: open-drain drive never pulls the line high
  p_od_low_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_q == PD_OPEN) |-> !irq_o);

  // R10: strobes are exclusive and read data updates only on a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;
  localparam int N  = 8;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq_o, irq_oe;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_irq_hub #(.N_SRC(N)) u_evt_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .irq_oe(irq_oe)
  );

  // {mode, mask, first src, second src, expected status}
  localparam int VW = DW + 4 * N;
  localparam logic [VW-1:0] VEC [6] = '{
    {16'h0000, 8'hFF, 8'h00, 8'h0F, 8'h0F},
    {16'h5555, 8'hFF, 8'hFF, 8'hF0, 8'h0F},
    {16'hAAAA, 8'h0F, 8'h00, 8'h3C, 8'h3C},
    {16'hFFFF, 8'hFF, 8'h00, 8'hFF, 8'h00},
    {16'hFA50, 8'h80, 8'h0C, 8'h33, 8'h3F},
    {16'h0000, 8'hFF, 8'hFF, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic settle(input logic [N-1:0] s);
    @(negedge clk); src = s;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 pin", {irq_oe, irq_o}, 2'b10);
    rd(2'd0, r); check("R1 status", r, '0);
    rd(2'd1, r); check("R1 mask", r, '0);
    rd(2'd2, r); check("R1 mode", r, '1);
    rd(2'd3, r); check("R1 drive", r, '0);

    // table: R2 R3 R4 R5 R8 patterns
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] m;
      logic [N-1:0] mk, a, b, e;
      {m, mk, a, b, e} = VEC[k];
      wr(2'd2, m);
      wr(2'd1, DW'(mk));
      settle(a);
      wr(2'd0, '1);
      settle(b);
      check("R8 pin", {irq_oe, irq_o}, {1'b1, |(e & mk)});
      rd(2'd0, r);
      check("R2/R3/R4/R5 status", r, DW'(e));
    end

    // R10 mode readback keeps the last value
    rd(2'd2, r); check("R10 mode readback", r, 16'h0000);

    // R2 latency: nothing after two edges, event after the third
    settle('0); wr(2'd0, '1); wr(2'd1, DW'(8'hFF));
    @(negedge clk); src = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 two edges", irq_o, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R2 three edges", irq_o, 1'b1);

    // R6 selective write-one clear, R7 read clear
    settle(8'hFF);
    wr(2'd0, DW'(8'h0F));
    rd(2'd0, r); check("R6 selective clear", r, DW'(8'hF0));
    rd(2'd0, r); check("R7 read clear", r, '0);

    // R4 level not sticky
    wr(2'd2, '1 ^ DW'(2'b01));  // source 0 level (2'b10), others off
    settle(8'h01);
    rd(2'd0, r); check("R4 level high", r, DW'(8'h01));
    settle(8'h00);
    rd(2'd0, r); check("R4 level drop", r, '0);

    // R9 drive modes with source 0 level-high
    settle(8'h01);
    wr(2'd3, DW'(2'b00)); @(negedge clk); check("R9 high", {irq_oe, irq_o}, 2'b11);
    wr(2'd3, DW'(2'b01)); @(negedge clk); check("R9 low", {irq_oe, irq_o}, 2'b10);
    wr(2'd3, DW'(2'b10)); @(negedge clk); check("R9 open active", {irq_oe, irq_o}, 2'b10);
    settle(8'h00);
    check("R9 open idle", {irq_oe, irq_o}, 2'b00);
    wr(2'd3, DW'(2'b11)); @(negedge clk); check("R9 alt low idle", {irq_oe, irq_o}, 2'b11);
    rd(2'd3, r); check("R10 drive readback", r, DW'(2'b11));

    // R8 status readable while masked
    wr(2'd1, '0); settle(8'h01);
    rd(2'd0, r); check("R8 masked status", r, DW'(8'h01));
    check("R8 masked pin", {irq_oe, irq_o}, 2'b11);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule